// File: doc/BRIEF.md
# Bus Master Upper-Address Page Loader

This sequencer sits inside a 32-bit bus master whose package has no pins for address bits 31:10. Those bits reach the bus through external transparent octal latches. The latches are loaded over the shared data pins. The block takes a transfer request as a valid/ready stream. The request carries a start address and a burst length, and the block expands it into one beat per 32-bit word on a second valid/ready stream. A separate data-phase engine consumes that stream.

Before a beat reaches the data-phase engine, the block checks whether the external latches already hold that beat's 1 KB page. If they do not, it inserts a two-clock load cycle. In the first clock it drives the page number onto the data pins, with the buffers enabled outbound and the latch enable low. In the second clock the latch enable goes high while the pins are still driven, so the latches close on stable data. The pins are released after that.

The block forgets the loaded page whenever bus ownership is lost, so the first beat after every new grant is preceded by a load. Back-pressure works as follows:
- A request is taken only when `req_valid` and `req_ready` are both high at a clock edge.
- A beat is taken only when `beat_valid` and `beat_ready` are both high.
- While a beat is offered and not yet taken, its address is held.
- A load cycle keeps `beat_valid` low.

Top module: `upl_page_loader`

## Requirements
- R1: After reset the pins are undriven (`ad_drive`=0), `le_n`=1, `buf_oe_n`=1, `buf_dir`=0, `beat_valid`=0, and `req_ready` is 0 while `grant` is low.
- R2: `req_ready` is 1 only when no transfer is active and `grant` is 1. A request offered while `grant` is 0 is not taken and produces no beat or load cycle.
- R3: The first beat after a grant is always preceded by a load cycle, whatever address was loaded before.
- R4: In the first clock of a load cycle, `ad_drive`=1 and `ad_out` equals the beat address with bits 9:0 forced to zero. In that clock `le_n`=0, `buf_oe_n`=0 and `buf_dir`=1 (1 means outbound).
- R5: In the second clock of a load cycle, `le_n`=1 while `ad_drive`=1, `ad_out` is unchanged, `buf_oe_n`=0 and `buf_dir`=1. In the following clock the first beat is offered.
- R6: `beat_valid` is 0 throughout a load cycle. While `beat_valid`=1 and `beat_ready`=0, the beat stays valid and `beat_addr` does not change.
- R7: A request with length field L yields L+1 beats. Beat i carries the word-aligned address (`req_addr` with bits 1:0 cleared) + 4·i, modulo 2^32. After the last beat is taken the block is idle in the next clock.
- R8: A load cycle is inserted before a beat exactly when its address bits 31:10 differ from the last loaded page, or no page is valid. This rule applies inside a burst and across back-to-back requests, single-beat or burst.
- R9: If `grant` is 0 at a clock edge, any transfer in progress is abandoned. In the next clock `beat_valid`=0 and `ad_drive`=0, and the loaded page is forgotten.
- R10: Outside load cycles, `ad_drive`=0, `le_n`=1, `buf_oe_n`=1 and `buf_dir`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| grant | input | 1 | Bus ownership granted to this master |
| req_valid | input | 1 | Transfer request offered |
| req_ready | output | 1 | Request can be taken this clock |
| req_addr | input | 32 | Start byte address (bits 1:0 ignored) |
| req_len | input | 8 | Number of beats minus one |
| beat_valid | output | 1 | Beat ready for the data phase; low during load cycles |
| beat_ready | input | 1 | Data phase takes the offered beat |
| beat_addr | output | 32 | Word-aligned byte address of the offered beat |
| ad_out | output | 32 | Value for the shared data/address pins |
| ad_drive | output | 1 | Drive enable for the shared pins |
| le_n | output | 1 | Active-low latch enable for the external page latches |
| buf_oe_n | output | 1 | Active-low enable of the external data buffers |
| buf_dir | output | 1 | Buffer direction, 1 = outbound toward the bus |

## Verification
The assertions assume that `beat_ready` is driven to a known level every clock. They also assume that the data-phase engine does not expect a beat while `grant` is low. Under those assumptions, stalled beats and aborted load cycles are judged only in clocks where `grant` was high at the edge.

The stimulus changes `grant`, `req_valid` and `beat_ready` only away from the active edge. It withdraws `grant` only at the chosen abort point, and it keeps `req_valid` low except while it is offering a request. The sweep steps start offsets toward the end of a page and varies burst lengths and stall counts, so that page crossings fall on every beat position of a short burst.

// File: rtl/upl_pkg.sv
package upl_pkg;
  // Sequencer states: idle, two load clocks, beat offered.
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD1 = 2'd1,
    ST_LOAD2 = 2'd2,
    ST_BEAT  = 2'd3
  } upl_state_e;
endpackage

// File: rtl/upl_addr_walker.sv
// Holds the current word address and the count of beats still to come.
module upl_addr_walker #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  start_len,
  input  logic              step,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] nxt_addr,
  output logic              last
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word_q;
  logic [LEN_W-1:0]  left_q;
  logic [WORD_W-1:0] word_inc;

  assign word_inc = word_q + {{(WORD_W-1){1'b0}}, 1'b1};
  assign cur_addr = {word_q, 2'b00};
  assign nxt_addr = {word_inc, 2'b00};
  assign last     = (left_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      left_q <= '0;
    end else if (start) begin
      word_q <= start_addr[ADDR_W-1:2];
      left_q <= start_len;
    end else if (step && !last) begin
      word_q <= word_inc;
      left_q <= left_q - {{(LEN_W-1){1'b0}}, 1'b1};
    end
  end
endmodule

// File: rtl/upl_page_tracker.sv
// Remembers which page the external latches hold, and whether that copy is valid.
module upl_page_tracker #(
  parameter int ADDR_W   = 32,
  parameter int PAGE_LSB = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       forget,
  input  logic                       capture,
  input  logic [ADDR_W-PAGE_LSB-1:0] capture_page,
  input  logic [ADDR_W-PAGE_LSB-1:0] probe_page,
  output logic                       hit
);
  localparam int PAGE_W = ADDR_W - PAGE_LSB;

  logic [PAGE_W-1:0] page_q;
  logic              valid_q;

  assign hit = valid_q && (probe_page == page_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q  <= '0;
      valid_q <= 1'b0;
    end else if (forget) begin
      valid_q <= 1'b0;
    end else if (capture) begin
      page_q  <= capture_page;
      valid_q <= 1'b1;
    end
  end
endmodule

// File: rtl/upl_seq_fsm.sv
// Orders load cycles and beats; loss of ownership returns to idle from any state.
module upl_seq_fsm
  import upl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       grant,
  input  logic       accept,
  input  logic       step,
  input  logic       last,
  input  logic       hit,
  output upl_state_e state
);
  upl_state_e state_d;

  always_comb begin
    state_d = state;
    if (!grant) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE:  if (accept) state_d = hit ? ST_BEAT : ST_LOAD1;
        ST_LOAD1: state_d = ST_LOAD2;
        ST_LOAD2: state_d = ST_BEAT;
        ST_BEAT: begin
          if (step) begin
            if (last)     state_d = ST_IDLE;
            else if (hit) state_d = ST_BEAT;
            else          state_d = ST_LOAD1;
          end
        end
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end
endmodule

// File: rtl/upl_page_loader.sv
module upl_page_loader
  import upl_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int PAGE_LSB = 10,
  parameter int LEN_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grant,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              beat_valid,
  input  logic              beat_ready,
  output logic [ADDR_W-1:0] beat_addr,
  output logic [ADDR_W-1:0] ad_out,
  output logic              ad_drive,
  output logic              le_n,
  output logic              buf_oe_n,
  output logic              buf_dir
);
  localparam int PAGE_W = ADDR_W - PAGE_LSB;

  upl_state_e        state;
  logic              accept;
  logic              step;
  logic              last;
  logic              hit;
  logic              in_load;
  logic [ADDR_W-1:0] cur_addr;
  logic [ADDR_W-1:0] nxt_addr;
  logic [PAGE_W-1:0] probe_page;

  assign req_ready  = (state == ST_IDLE) && grant;
  assign accept     = req_valid && req_ready;
  assign beat_valid = (state == ST_BEAT);
  assign step       = beat_valid && beat_ready;
  assign beat_addr  = cur_addr;
  assign in_load    = (state == ST_LOAD1) || (state == ST_LOAD2);

  // The page is checked on the request address when a transfer starts,
  // and on the following word address when a beat is taken.
  assign probe_page = (state == ST_IDLE) ? req_addr[ADDR_W-1:PAGE_LSB]
                                         : nxt_addr[ADDR_W-1:PAGE_LSB];

  upl_addr_walker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_walker (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .start_addr (req_addr),
    .start_len  (req_len),
    .step       (step),
    .cur_addr   (cur_addr),
    .nxt_addr   (nxt_addr),
    .last       (last)
  );

  upl_page_tracker #(.ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB)) u_tracker (
    .clk          (clk),
    .rst_n        (rst_n),
    .forget       (!grant),
    .capture      (state == ST_LOAD1),
    .capture_page (cur_addr[ADDR_W-1:PAGE_LSB]),
    .probe_page   (probe_page),
    .hit          (hit)
  );

  upl_seq_fsm u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .grant  (grant),
    .accept (accept),
    .step   (step),
    .last   (last),
    .hit    (hit),
    .state  (state)
  );

  // Pin side: page number on the shared pins, low bits zero, only in load clocks.
  assign ad_drive = in_load;
  assign ad_out   = in_load ? {cur_addr[ADDR_W-1:PAGE_LSB], {PAGE_LSB{1'b0}}} : '0;
  assign le_n     = (state != ST_LOAD1);
  assign buf_oe_n = !in_load;
  assign buf_dir  = in_load;
endmodule

// File: rtl/upl_page_loader_chk.sv
module upl_page_loader_chk #(
  parameter int ADDR_W   = 32,
  parameter int PAGE_LSB = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              grant,
  input logic              req_ready,
  input logic              beat_valid,
  input logic              beat_ready,
  input logic [ADDR_W-1:0] beat_addr,
  input logic [ADDR_W-1:0] ad_out,
  input logic              ad_drive,
  input logic              le_n,
  input logic              buf_oe_n,
  input logic              buf_dir
);
  AST_READY_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (grant && !beat_valid && !ad_drive)); // R2
  AST_STROBE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    !le_n |-> (ad_drive && !buf_oe_n && buf_dir && ad_out[PAGE_LSB-1:0] == '0)); // R4
  AST_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_n && grant) |=> (le_n && ad_drive && $stable(ad_out))); // R5
  AST_NO_BEAT_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ad_drive |-> !beat_valid); // R6
  AST_BEAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_ready && grant) |=> (beat_valid && $stable(beat_addr))); // R6
  AST_DROP_ON_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    !grant |=> (!beat_valid && !ad_drive)); // R9
  AST_QUIET_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    !ad_drive |-> (le_n && buf_oe_n && !buf_dir)); // R10
endmodule

bind upl_page_loader upl_page_loader_chk #(.ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .grant      (grant),
  .req_ready  (req_ready),
  .beat_valid (beat_valid),
  .beat_ready (beat_ready),
  .beat_addr  (beat_addr),
  .ad_out     (ad_out),
  .ad_drive   (ad_drive),
  .le_n       (le_n),
  .buf_oe_n   (buf_oe_n),
  .buf_dir    (buf_dir)
);

// File: tb/upl_page_loader_test.sv
module upl_page_loader_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        grant = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [7:0]  req_len = '0;
  logic        beat_valid;
  logic        beat_ready = 1'b0;
  logic [31:0] beat_addr;
  logic [31:0] ad_out;
  logic        ad_drive;
  logic        le_n;
  logic        buf_oe_n;
  logic        buf_dir;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Reference page state, kept from the requirements.
  bit          m_valid = 1'b0;
  logic [21:0] m_page = '0;

  always #2 clk = ~clk;

  upl_page_loader uut (
    .clk(clk), .rst_n(rst_n), .grant(grant),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len),
    .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_addr(beat_addr),
    .ad_out(ad_out), .ad_drive(ad_drive), .le_n(le_n), .buf_oe_n(buf_oe_n), .buf_dir(buf_dir)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_quiet(input string req);
    check(req, {28'd0, ad_drive, le_n, buf_oe_n, buf_dir}, 32'b0110);
  endtask

  // Issue one request at a negedge where the block is idle, then follow every clock.
  task automatic run_req(input logic [31:0] addr, input logic [7:0] len);
    logic [31:0] base;
    base = {addr[31:2], 2'b00};
    check("R2 ready when idle", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_addr = addr; req_len = len;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i <= int'(len); i++) begin
      logic [31:0] a;
      int stalls;
      a = base + 32'(4 * i);
      if (!m_valid || a[31:10] != m_page) begin
        check("R4 load1 pins", ad_out, {a[31:10], 10'd0});
        check("R4 load1 ctl", {28'd0, ad_drive, le_n, buf_oe_n, buf_dir}, 32'b1001);
        check("R6 no beat in load1", {31'd0, beat_valid}, 32'd0);
        @(negedge clk);
        check("R5 load2 pins", ad_out, {a[31:10], 10'd0});
        check("R5 load2 ctl", {28'd0, ad_drive, le_n, buf_oe_n, buf_dir}, 32'b1101);
        check("R6 no beat in load2", {31'd0, beat_valid}, 32'd0);
        @(negedge clk);
        m_valid = 1'b1; m_page = a[31:10];
      end
      stalls = (i + int'(len)) % 3;
      for (int s = 0; s < stalls; s++) begin
        beat_ready = 1'b0;
        check("R6 stalled beat valid", {31'd0, beat_valid}, 32'd1);
        check("R6 stalled beat addr", beat_addr, a);
        @(negedge clk);
      end
      beat_ready = 1'b1;
      check("R8 beat without extra load", {31'd0, beat_valid}, 32'd1);
      check("R7 beat addr", beat_addr, a);
      chk_quiet("R10 pins quiet on beat");
      @(negedge clk);
      beat_ready = 1'b0;
    end
    check("R7 idle after last beat", {30'd0, beat_valid, req_ready}, 32'b01);
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    done = 1'b1;
  end

  initial begin
    logic [31:0] a;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset beat_valid", {31'd0, beat_valid}, 32'd0);
    check("R1 reset req_ready", {31'd0, req_ready}, 32'd0);
    chk_quiet("R1 reset pins");
    rst_n = 1'b1;
    @(negedge clk);
    // R2: request ignored without grant
    req_valid = 1'b1; req_addr = 32'h0000_1000; req_len = 8'd2;
    @(negedge clk);
    check("R2 no ready without grant", {31'd0, req_ready}, 32'd0);
    @(negedge clk);
    check("R2 nothing started", {30'd0, beat_valid, ad_drive}, 32'd0);
    req_valid = 1'b0;
    grant = 1'b1;
    @(negedge clk);
    // R3/R7/R8 sweep: offsets near page end, lengths 0..6, varied pages
    for (int k = 0; k < 6; k++) begin
      for (int l = 0; l < 7; l++) begin
        a = {10'(k * 37 + l * 5), 12'h0, 10'd0} + 32'h400 - 32'(4 * k) + 32'(l & 3);
        run_req(a, 8'(l));
        if (l == 3) run_req(a + 32'd4, 8'd0); // R8 same page single: no load expected if page held
      end
    end
    // R9: drop grant mid-burst, page must be forgotten
    a = 32'h1234_5800;
    run_req(a, 8'd0);
    req_valid = 1'b1; req_addr = a; req_len = 8'd3;
    @(negedge clk);
    req_valid = 1'b0;
    check("R8 same page no load", {31'd0, beat_valid}, 32'd1);
    grant = 1'b0;
    @(negedge clk);
    check("R9 abandoned", {29'd0, beat_valid, ad_drive, req_ready}, 32'd0);
    m_valid = 1'b0;
    @(negedge clk);
    grant = 1'b1;
    @(negedge clk);
    run_req(a, 8'd1); // R3 load again after regrant
    // R9 also at abort during load clock 1
    req_valid = 1'b1; req_addr = 32'h0ABC_0000; req_len = 8'd0;
    @(negedge clk);
    req_valid = 1'b0;
    check("R8 new page load", {31'd0, le_n}, 32'd0);
    grant = 1'b0;
    @(negedge clk);
    check("R9 abort in load", {29'd0, beat_valid, ad_drive, le_n}, 32'd1);
    m_valid = 1'b0;
    grant = 1'b1;
    @(negedge clk);
    run_req(32'h0ABC_0000, 8'd2);
    done = 1'b1;
  end

  initial begin
    wait (done);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule